// File: doc/BRIEF.md
# DMA Descriptor Status Tracker

This block keeps the end-of-transfer status of four DMA descriptors. The transfer engine sends it one pulse per descriptor when a transfer finishes normally. When a transfer fails it sends a separate pulse for a source-side error or a destination-side error. For each descriptor the block holds two flags:

- a completion flag, raised by any ending of the transfer;
- an error flag, raised only by a failure.

Both flags appear together in one read-only status word.

Software clears a descriptor's flags in one of two ways. It can write a one to that descriptor's bit of a write-one-to-clear register, seen here as a write strobe and a data mask. Or the descriptor can be re-armed, which the control-register logic reports as a valid-bit-set strobe. A level interrupt is raised while any completion flag is set for a descriptor whose interrupt enable is high.

Top module: `dma_desc_status`

## Requirements
- R1: After reset, every bit of `status_o` is 0 and `irq_o` is 0.
- R2: A `done_i[i]` pulse sets status bit 4+i (completion of descriptor i) at the next clock edge and leaves status bit 8+i unchanged.
- R3: A `src_err_i[i]` or `dst_err_i[i]` pulse sets both status bit 4+i and status bit 8+i (error of descriptor i) at the next clock edge.
- R4: `clr_wr_i` high with `clr_mask_i[i]` = 1 clears status bits 4+i and 8+i at the next edge. Mask bits at 0 leave their descriptor unchanged. While `clr_wr_i` is low, the mask has no effect.
- R5: `arm_i[i]` high clears status bits 4+i and 8+i at the next edge.
- R6: If a clear (from R4 or R5) and a set event reach the same descriptor in one cycle, each flag that the set event raises ends up at 1. A flag that the set event does not raise is cleared.
- R7: Status bits 0 to 3 and bits 12 to 31 always read 0.
- R8: `irq_o` equals the OR over i of (status bit 4+i AND `irq_en_i[i]`), at all times. It falls once the enabled completion flags are cleared.
- R9: With no set event and no clear for a descriptor, both of its flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 4 | Per-descriptor normal-completion pulse |
| src_err_i | input | 4 | Per-descriptor source-side error pulse |
| dst_err_i | input | 4 | Per-descriptor destination-side error pulse |
| clr_wr_i | input | 1 | Write strobe of the interrupt-clear register |
| clr_mask_i | input | 4 | Write data of the interrupt-clear register, one bit per descriptor |
| arm_i | input | 4 | Per-descriptor valid-bit-set strobe |
| irq_en_i | input | 4 | Per-descriptor interrupt enable |
| status_o | output | 32 | Status word: completion at bits 7:4, error at bits 11:8 |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults:

- four descriptors;
- a 32-bit status word;
- completion flags from bit 4, with the error field directly above.

This layout places both reserved regions, the low nibble and bits 12 to 31, in reach of a reserved-bit check. Random stimulus with sparse clears lets flags accumulate, so simultaneous set/clear collisions on one descriptor occur often. Directed steps cover each clear path alone, a zero clear mask, and interrupt masking.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  typedef struct packed {
    logic done;
    logic src_err;
    logic dst_err;
    logic clr;
  } desc_ev_t;
endpackage

// File: rtl/dma_stat_flag_cell.sv
module dma_stat_flag_cell
  import dma_stat_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  desc_ev_t ev_i,
  output logic     cmp_o,
  output logic     err_o
);
  logic set_cmp, set_err;
  logic cmp_q, err_q;

  assign set_err = ev_i.src_err | ev_i.dst_err;
  assign set_cmp = ev_i.done | set_err;

  // set dominates clear so no completion is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (set_cmp)       cmp_q <= 1'b1;
      else if (ev_i.clr) cmp_q <= 1'b0;
      if (set_err)       err_q <= 1'b1;
      else if (ev_i.clr) err_q <= 1'b0;
    end
  end

  assign cmp_o = cmp_q;
  assign err_o = err_q;
endmodule

// File: rtl/dma_stat_pack.sv
module dma_stat_pack #(
  parameter int N_DESC  = 4,
  parameter int STAT_W  = 32,
  parameter int CMP_LSB = 4,
  parameter int ERR_LSB = 8
) (
  input  logic [N_DESC-1:0] cmp_i,
  input  logic [N_DESC-1:0] err_i,
  output logic [STAT_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    word_o[CMP_LSB +: N_DESC] = cmp_i;
    word_o[ERR_LSB +: N_DESC] = err_i;
  end
endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq #(
  parameter int N_DESC = 4
) (
  input  logic [N_DESC-1:0] cmp_i,
  input  logic [N_DESC-1:0] en_i,
  output logic              irq_o
);
  assign irq_o = |(cmp_i & en_i);
endmodule

// File: rtl/dma_desc_status.sv
module dma_desc_status
  import dma_stat_pkg::*;
#(
  parameter int N_DESC  = 4,
  parameter int STAT_W  = 32,
  parameter int CMP_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_DESC-1:0] done_i,
  input  logic [N_DESC-1:0] src_err_i,
  input  logic [N_DESC-1:0] dst_err_i,
  input  logic              clr_wr_i,
  input  logic [N_DESC-1:0] clr_mask_i,
  input  logic [N_DESC-1:0] arm_i,
  input  logic [N_DESC-1:0] irq_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  localparam int ERR_LSB = CMP_LSB + N_DESC;

  logic [N_DESC-1:0] clr_hit;
  logic [N_DESC-1:0] cmp_flags, err_flags;

  assign clr_hit = ({N_DESC{clr_wr_i}} & clr_mask_i) | arm_i;

  for (genvar i = 0; i < N_DESC; i++) begin : g_desc
    desc_ev_t ev;
    assign ev = '{done: done_i[i], src_err: src_err_i[i],
                  dst_err: dst_err_i[i], clr: clr_hit[i]};
    dma_stat_flag_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ev_i  (ev),
      .cmp_o (cmp_flags[i]),
      .err_o (err_flags[i])
    );
  end

  dma_stat_pack #(
    .N_DESC (N_DESC),
    .STAT_W (STAT_W),
    .CMP_LSB(CMP_LSB),
    .ERR_LSB(ERR_LSB)
  ) u_pack (
    .cmp_i (cmp_flags),
    .err_i (err_flags),
    .word_o(status_o)
  );

  dma_stat_irq #(.N_DESC(N_DESC)) u_irq (
    .cmp_i(cmp_flags),
    .en_i (irq_en_i),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/dma_desc_status_chk.sv
module dma_desc_status_chk #(
  parameter int N_DESC  = 4,
  parameter int STAT_W  = 32,
  parameter int CMP_LSB = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_DESC-1:0] done_i,
  input logic [N_DESC-1:0] src_err_i,
  input logic [N_DESC-1:0] dst_err_i,
  input logic              clr_wr_i,
  input logic [N_DESC-1:0] clr_mask_i,
  input logic [N_DESC-1:0] arm_i,
  input logic [N_DESC-1:0] irq_en_i,
  input logic [STAT_W-1:0] status_o,
  input logic              irq_o
);
  localparam int ERR_LSB = CMP_LSB + N_DESC;
  localparam logic [STAT_W-1:0] USED = {{(STAT_W-2*N_DESC){1'b0}}, {(2*N_DESC){1'b1}}} << CMP_LSB;

  logic [N_DESC-1:0] ev_err, ev_any, ev_clr;
  assign ev_err = src_err_i | dst_err_i;
  assign ev_any = ev_err | done_i;
  assign ev_clr = (clr_wr_i ? clr_mask_i : '0) | arm_i;

  // R7
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~USED) == '0);

  // R8
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(status_o[CMP_LSB +: N_DESC] & irq_en_i));

  for (genvar i = 0; i < N_DESC; i++) begin : g_chk
    // R2
    cmp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_any[i] |=> status_o[CMP_LSB+i]);
    // R3
    err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_err[i] |=> status_o[ERR_LSB+i]);
    // R6
    err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_clr[i] && !ev_err[i]) |=> !status_o[ERR_LSB+i]);
    // R4
    cmp_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_clr[i] && !ev_any[i]) |=> !status_o[CMP_LSB+i]);
    // R9
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev_clr[i] && !ev_any[i]) |=>
        $stable(status_o[CMP_LSB+i]) && $stable(status_o[ERR_LSB+i]));
  end
endmodule

bind dma_desc_status dma_desc_status_chk #(
  .N_DESC(N_DESC), .STAT_W(STAT_W), .CMP_LSB(CMP_LSB)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .src_err_i(src_err_i),
  .dst_err_i(dst_err_i), .clr_wr_i(clr_wr_i), .clr_mask_i(clr_mask_i),
  .arm_i(arm_i), .irq_en_i(irq_en_i), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/tb_dma_desc_status.sv
module tb_dma_desc_status;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] done_i = '0, src_err_i = '0, dst_err_i = '0;
  logic         clr_wr_i = 1'b0;
  logic [N-1:0] clr_mask_i = '0, arm_i = '0, irq_en_i = '0;
  logic [31:0]  status_o;
  logic         irq_o;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] m_cmp = '0, m_err = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_desc_status dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .src_err_i(src_err_i),
    .dst_err_i(dst_err_i), .clr_wr_i(clr_wr_i), .clr_mask_i(clr_mask_i),
    .arm_i(arm_i), .irq_en_i(irq_en_i), .status_o(status_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] pack(logic [N-1:0] c, logic [N-1:0] e);
    return {20'd0, e, c, 4'd0};
  endfunction

  function automatic logic exp_irq(logic [N-1:0] c, logic [N-1:0] en);
    return |(c & en);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // apply current inputs for one edge; update model; return at negedge
  task automatic tick();
    logic [N-1:0] er, st, cl;
    er = src_err_i | dst_err_i;
    st = er | done_i;
    cl = (clr_wr_i ? clr_mask_i : '0) | arm_i;
    for (int i = 0; i < N; i++) begin
      if (st[i]) m_cmp[i] = 1'b1; else if (cl[i]) m_cmp[i] = 1'b0;
      if (er[i]) m_err[i] = 1'b1; else if (cl[i]) m_err[i] = 1'b0;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    done_i = '0; src_err_i = '0; dst_err_i = '0;
    clr_wr_i = 1'b0; clr_mask_i = '0; arm_i = '0;
  endtask

  initial begin
    int unsigned r;
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk_i);
    chk("R1 status", status_o, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done_i = 4'b0010; tick();
    chk("R2 done d1", status_o, 32'h0000_0020);
    src_err_i = 4'b0100; tick();
    chk("R3 src err d2", status_o, 32'h0000_0460);
    dst_err_i = 4'b1000; tick();
    chk("R3 dst err d3", status_o, 32'h0000_0CE0);

    irq_en_i = 4'b0100; #1;
    chk("R8 irq enabled d2", {31'd0, irq_o}, 32'd1);
    irq_en_i = 4'b0001; #1;
    chk("R8 irq masked", {31'd0, irq_o}, 32'd0);

    clr_wr_i = 1'b1; clr_mask_i = 4'b0000; tick();
    chk("R4 zero mask", status_o, 32'h0000_0CE0);
    clr_mask_i = 4'b1110; tick();
    chk("R4 no strobe", status_o, 32'h0000_0CE0);
    clr_wr_i = 1'b1; clr_mask_i = 4'b0100; tick();
    chk("R4 clear d2", status_o, 32'h0000_08A0);
    arm_i = 4'b1000; tick();
    chk("R5 arm d3", status_o, 32'h0000_0020);

    irq_en_i = 4'b1111; #1;
    chk("R8 irq d1", {31'd0, irq_o}, 32'd1);
    arm_i = 4'b0010; tick();
    chk("R8 irq drop", {31'd0, irq_o}, 32'd0);

    done_i = 4'b0001; clr_wr_i = 1'b1; clr_mask_i = 4'b0001; tick();
    chk("R6 done beats clear", status_o, 32'h0000_0010);
    src_err_i = 4'b0010; arm_i = 4'b0010; tick();
    chk("R6 err beats arm", status_o, 32'h0000_0230);
    dst_err_i = 4'b0001; tick();
    done_i = 4'b0001; arm_i = 4'b0001; tick();
    chk("R6 done clears err", status_o, 32'h0000_0230);
    repeat (3) tick();
    chk("R9 hold", status_o, 32'h0000_0230);

    for (int k = 0; k < 3000; k++) begin
      r = $urandom();
      done_i    = r[3:0] & r[7:4];
      src_err_i = r[11:8] & r[15:12] & r[19:16];
      dst_err_i = r[23:20] & r[27:24] & r[31:28];
      r = $urandom();
      clr_wr_i   = (r[3:0] == 4'd0);
      clr_mask_i = r[7:4];
      arm_i      = r[11:8] & r[15:12] & r[19:16] & r[23:20];
      irq_en_i   = r[27:24];
      tick();
      chk("R9 random status", status_o, pack(m_cmp, m_err));
      chk("R7 reserved", status_o & 32'hFFFF_F00F, 32'h0);
      chk("R8 random irq", {31'd0, irq_o}, {31'd0, exp_irq(m_cmp, irq_en_i)});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule